// File: doc/BRIEF.md
# Paged Effective Address Unit

This unit turns a memory-reference instruction on a 12-bit word machine into a 15-bit physical address. The instruction carries a 7-bit offset, a page-select bit and an indirect bit. The offset lands either in page zero of the field or in the 128-word page the instruction came from. The 3-bit field on top comes from one of three registers that the unit holds: the data field, the instruction field, and an instruction buffer that waits for the next jump.

When the indirect bit is set, the unit reads a pointer word through its own memory request port. The pointer is always read from the current instruction field. A pointer held in one of eight page-zero locations (octal 0010 to 0017) is incremented, written back, and the new value is used. The unit also decodes the field-change and field-read I/O commands. A strobe marks the cycle in which the final address is valid.

Top module: `paged_ea_unit`

## Requirements
- R1: With the page bit (instruction bit value octal 0200) clear, the low 12 bits of the address are the 7-bit offset (bits value 0177) with zeros above.
- R2: With the page bit set, the upper 5 of the low 12 address bits come from the fetch address and the lower 7 from the offset.
- R3: A direct operand of a non-jump opcode (opcodes 0 to 3 in the top three bits) uses the instruction field, whatever the data field holds.
- R4: With the indirect bit (value octal 0400) set, the pointer is read at {instruction field, page address}, and a non-jump operand address is {data field, pointer}.
- R5: An indirect pointer at page-zero locations 0010 to 0017 is written back as pointer plus one, modulo 4096, and that new value forms the address. Pointers anywhere else are never written.
- R6: A field command (device group octal 2x, x the field, pulse bit value 1 set, pulse bit value 4 clear) loads the data field at the next clock.
- R7: A field command with pulse bit value 2 loads only the instruction buffer. The instruction field takes the buffer value when a JMS (opcode 4) or JMP (opcode 5) completes, and at no other time.
- R8: Pulse value 3 loads both the data field and the instruction buffer with the same field.
- R9: A JMP or JMS target, direct or indirect, takes its field from the instruction buffer.
- R10: Device octal 21 with pulse 4 reads the data field, and device 22 with pulse 4 reads the instruction field. The result is one cycle later on the readback port, at word bits 5:3 (bits 6-8 counted from the MSB), with all other bits zero.
- R11: The done strobe lasts one cycle. It comes 1 cycle after start for a direct address, 3 cycles for a plain indirect address, and 4 cycles with auto-increment, given a memory that answers one cycle after the request.
- R12: After reset all three field registers are zero, the done strobe is low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ea_start | input | 1 | Begin address formation (taken only when idle) |
| ea_instr | input | 12 | Instruction word |
| ea_fetch_pc | input | 12 | Address the instruction was fetched from |
| iot_valid | input | 1 | I/O command strobe |
| iot_dev | input | 6 | I/O device code |
| iot_pulse | input | 3 | I/O pulse bits |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 12 | Write data (incremented pointer) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 12 | Read data |
| ea_done | output | 1 | Address valid strobe |
| ea_addr | output | 15 | Final field and address |
| ea_jump | output | 1 | Completed instruction was a JMP or JMS |
| fld_rd_valid | output | 1 | Field readback valid |
| fld_rd_word | output | 12 | Field readback word |
| field_df | output | 3 | Data field |
| field_if | output | 3 | Instruction field |
| field_ib | output | 3 | Instruction buffer |

## Verification
The bench builds the unit with its default parameters: 12-bit words, 7-bit offsets, 3-bit fields and auto-increment generated in. These defaults put all eight fields within reach, so each test sets the data field, instruction field and buffer to different values. A wrong choice of field then shows in the upper three address bits. The default word width also makes the octal 7777 pointer reachable, so the wrap to zero is checked at the auto-increment location.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PRD  = 2'd1,
      SQ_PWT  = 2'd2,
      SQ_PWB  = 2'd3
   } ea_seq_e;

   localparam int OPC_W = 3;
   localparam logic [2:0] OPC_JMS = 3'd4;
   localparam logic [2:0] OPC_JMP = 3'd5;
endpackage

// File: rtl/ea_page_form.sv
module ea_page_form #(
   parameter int WORD_W    = 12,
   parameter int OFFS_W    = 7,
   parameter bit AUTO_EN   = 1'b1,
   parameter int AUTO_BASE = 8
) (
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] fetch_pc,
   output logic [WORD_W-1:0] page_addr,
   output logic              is_ind,
   output logic              is_jump,
   output logic              is_auto
);
   import ea_pkg::*;
   localparam int PAGE_HI = WORD_W - OFFS_W;
   localparam int BIT_PG  = OFFS_W;
   localparam int BIT_IND = OFFS_W + 1;

   logic [OPC_W-1:0] opc;
   logic             pg_sel;

   assign opc     = instr[WORD_W-1 -: OPC_W];
   assign pg_sel  = instr[BIT_PG];
   assign is_ind  = instr[BIT_IND];
   assign is_jump = (opc == OPC_JMS) || (opc == OPC_JMP);

   always_comb begin
      page_addr = '0;
      page_addr[OFFS_W-1:0] = instr[OFFS_W-1:0];
      if (pg_sel)
         page_addr[WORD_W-1:OFFS_W] = fetch_pc[WORD_W-1:OFFS_W];
   end

   generate
      if (AUTO_EN) begin : g_auto
         localparam logic [WORD_W-1:0] AB = WORD_W'(AUTO_BASE);
         assign is_auto = is_ind && (page_addr[WORD_W-1:3] == AB[WORD_W-1:3]);
      end else begin : g_noauto
         assign is_auto = 1'b0;
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = ^{PAGE_HI[0]};
endmodule

// File: rtl/ea_field_regs.sv
module ea_field_regs #(
   parameter int WORD_W    = 12,
   parameter int FIELD_W   = 3,
   parameter int DEV_W     = 6,
   parameter int DEV_GROUP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iot_valid,
   input  logic [DEV_W-1:0]   iot_dev,
   input  logic [2:0]         iot_pulse,
   input  logic               jump_commit,
   output logic [FIELD_W-1:0] df_q,
   output logic [FIELD_W-1:0] if_q,
   output logic [FIELD_W-1:0] ib_q,
   output logic               rd_valid,
   output logic [WORD_W-1:0]  rd_word
);
   localparam int RD_LSB = WORD_W - 9;
   localparam int SUB_W  = DEV_W - 3;
   localparam logic [SUB_W-1:0] GRP = SUB_W'(DEV_GROUP);

   logic               in_grp, set_df, set_ib, rd_df, rd_if;
   logic [FIELD_W-1:0] new_fld, rd_sel;

   assign in_grp  = iot_valid && (iot_dev[DEV_W-1:3] == GRP);
   assign new_fld = iot_dev[FIELD_W-1:0];
   assign set_df  = in_grp && !iot_pulse[2] && iot_pulse[0];
   assign set_ib  = in_grp && !iot_pulse[2] && iot_pulse[1];
   assign rd_df   = in_grp && (iot_pulse == 3'd4) && (iot_dev[2:0] == 3'd1);
   assign rd_if   = in_grp && (iot_pulse == 3'd4) && (iot_dev[2:0] == 3'd2);
   assign rd_sel  = rd_df ? df_q : if_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         df_q     <= '0;
         if_q     <= '0;
         ib_q     <= '0;
         rd_valid <= 1'b0;
         rd_word  <= '0;
      end else begin
         if (jump_commit) if_q <= ib_q;
         if (set_df)      df_q <= new_fld;
         if (set_ib)      ib_q <= new_fld;
         rd_valid <= rd_df || rd_if;
         rd_word  <= '0;
         if (rd_df || rd_if)
            rd_word <= WORD_W'(rd_sel) << RD_LSB;
      end
   end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq #(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [WORD_W-1:0]         page_addr,
   input  logic                      is_ind,
   input  logic                      is_jump,
   input  logic                      is_auto,
   input  logic [FIELD_W-1:0]        if_fld,
   input  logic [FIELD_W-1:0]        df_fld,
   input  logic [FIELD_W-1:0]        ib_fld,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [FIELD_W+WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0]         mem_wdata,
   input  logic                      mem_rvalid,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic                      jump_commit,
   output logic                      done,
   output logic [FIELD_W+WORD_W-1:0] addr,
   output logic                      jump_out
);
   import ea_pkg::*;

   ea_seq_e            st;
   logic [WORD_W-1:0]  pa_q, ptr_q, fin_low;
   logic               jmp_q, auto_q, fin, fin_jmp, fin_ind;
   logic [FIELD_W-1:0] fin_fld;

   always_comb begin
      fin     = 1'b0;
      fin_low = page_addr;
      fin_jmp = is_jump;
      fin_ind = 1'b0;
      unique case (st)
         SQ_IDLE: fin = start && !is_ind;
         SQ_PWT: begin
            fin     = mem_rvalid && !auto_q;
            fin_low = mem_rdata;
            fin_jmp = jmp_q;
            fin_ind = 1'b1;
         end
         SQ_PWB: begin
            fin     = 1'b1;
            fin_low = ptr_q;
            fin_jmp = jmp_q;
            fin_ind = 1'b1;
         end
         default: fin = 1'b0;
      endcase
      if (fin_jmp)      fin_fld = ib_fld;
      else if (fin_ind) fin_fld = df_fld;
      else              fin_fld = if_fld;
   end

   assign jump_commit = fin && fin_jmp;
   assign mem_req     = (st == SQ_PRD) || (st == SQ_PWB);
   assign mem_we      = (st == SQ_PWB);
   assign mem_addr    = {if_fld, pa_q};
   assign mem_wdata   = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         pa_q     <= '0;
         ptr_q    <= '0;
         jmp_q    <= 1'b0;
         auto_q   <= 1'b0;
         done     <= 1'b0;
         addr     <= '0;
         jump_out <= 1'b0;
      end else begin
         done <= fin;
         if (fin) begin
            addr     <= {fin_fld, fin_low};
            jump_out <= fin_jmp;
         end
         unique case (st)
            SQ_IDLE: if (start && is_ind) begin
               pa_q   <= page_addr;
               jmp_q  <= is_jump;
               auto_q <= is_auto;
               st     <= SQ_PRD;
            end
            SQ_PRD: st <= SQ_PWT;
            SQ_PWT: if (mem_rvalid) begin
               if (auto_q) begin
                  ptr_q <= mem_rdata + 1'b1;
                  st    <= SQ_PWB;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            SQ_PWB: st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit #(
   parameter int WORD_W    = 12,
   parameter int OFFS_W    = 7,
   parameter int FIELD_W   = 3,
   parameter int DEV_W     = 6,
   parameter int DEV_GROUP = 2,
   parameter bit AUTO_EN   = 1'b1,
   parameter int AUTO_BASE = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ea_start,
   input  logic [WORD_W-1:0]         ea_instr,
   input  logic [WORD_W-1:0]         ea_fetch_pc,
   input  logic                      iot_valid,
   input  logic [DEV_W-1:0]          iot_dev,
   input  logic [2:0]                iot_pulse,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [FIELD_W+WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0]         mem_wdata,
   input  logic                      mem_rvalid,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic                      ea_done,
   output logic [FIELD_W+WORD_W-1:0] ea_addr,
   output logic                      ea_jump,
   output logic                      fld_rd_valid,
   output logic [WORD_W-1:0]         fld_rd_word,
   output logic [FIELD_W-1:0]        field_df,
   output logic [FIELD_W-1:0]        field_if,
   output logic [FIELD_W-1:0]        field_ib
);
   generate
      if (OFFS_W + 2 + 3 > WORD_W) begin : g_bad_offs
         $error("offset, page and indirect bits do not fit under the opcode");
      end
      if (FIELD_W > 3 || FIELD_W < 1) begin : g_bad_fld
         $error("field width must be 1 to 3");
      end
      if (WORD_W < 9 || DEV_W < 4) begin : g_bad_word
         $error("word or device code too narrow");
      end
   endgenerate

   logic [WORD_W-1:0] page_addr;
   logic              is_ind, is_jump, is_auto, jump_commit;

   ea_page_form #(
      .WORD_W(WORD_W), .OFFS_W(OFFS_W), .AUTO_EN(AUTO_EN), .AUTO_BASE(AUTO_BASE)
   ) u_page (
      .instr(ea_instr), .fetch_pc(ea_fetch_pc), .page_addr(page_addr),
      .is_ind(is_ind), .is_jump(is_jump), .is_auto(is_auto)
   );

   ea_field_regs #(
      .WORD_W(WORD_W), .FIELD_W(FIELD_W), .DEV_W(DEV_W), .DEV_GROUP(DEV_GROUP)
   ) u_fld (
      .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_dev(iot_dev),
      .iot_pulse(iot_pulse), .jump_commit(jump_commit),
      .df_q(field_df), .if_q(field_if), .ib_q(field_ib),
      .rd_valid(fld_rd_valid), .rd_word(fld_rd_word)
   );

   ea_ptr_seq #(
      .WORD_W(WORD_W), .FIELD_W(FIELD_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(ea_start), .page_addr(page_addr),
      .is_ind(is_ind), .is_jump(is_jump), .is_auto(is_auto),
      .if_fld(field_if), .df_fld(field_df), .ib_fld(field_ib),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .jump_commit(jump_commit), .done(ea_done), .addr(ea_addr), .jump_out(ea_jump)
   );
endmodule

// File: rtl/paged_ea_unit_chk.sv
module paged_ea_unit_chk #(
   parameter int WORD_W    = 12,
   parameter int FIELD_W   = 3,
   parameter int DEV_W     = 6,
   parameter int DEV_GROUP = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      iot_valid,
   input logic [DEV_W-1:0]          iot_dev,
   input logic [2:0]                iot_pulse,
   input logic                      mem_req,
   input logic                      mem_we,
   input logic [FIELD_W+WORD_W-1:0] mem_addr,
   input logic                      ea_done,
   input logic [FIELD_W+WORD_W-1:0] ea_addr,
   input logic                      ea_jump,
   input logic [FIELD_W-1:0]        field_df,
   input logic [FIELD_W-1:0]        field_if
);
   localparam int TOP = FIELD_W + WORD_W - 1;
   logic cdf_cmd;
   assign cdf_cmd = iot_valid && (iot_dev[DEV_W-1:3] == (DEV_W-3)'(DEV_GROUP))
                    && !iot_pulse[2] && iot_pulse[0];

   a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ea_done |=> !ea_done);

   a_r5_write_only_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[WORD_W-1:3] == 1));

   a_r4_pointer_in_if: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[TOP -: FIELD_W] == field_if));

   a_r6_cdf_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
      cdf_cmd |=> (field_df == $past(iot_dev[FIELD_W-1:0])));

   a_r9_jump_field_current: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_done && ea_jump) |-> (field_if == ea_addr[TOP -: FIELD_W]));

   a_r7_if_moves_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (field_if != $past(field_if)) |-> (ea_done && ea_jump));
endmodule

bind paged_ea_unit paged_ea_unit_chk #(
   .WORD_W(WORD_W), .FIELD_W(FIELD_W), .DEV_W(DEV_W), .DEV_GROUP(DEV_GROUP)
) u_chk (.*);

// File: tb/paged_ea_unit_test.sv
module paged_ea_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ea_start = 1'b0;
   logic [11:0] ea_instr = '0, ea_fetch_pc = '0;
   logic        iot_valid = 1'b0;
   logic [5:0]  iot_dev = '0;
   logic [2:0]  iot_pulse = '0;
   logic        mem_req, mem_we, mem_rvalid = 1'b0;
   logic [14:0] mem_addr;
   logic [11:0] mem_wdata, mem_rdata = '0;
   logic        ea_done, ea_jump, fld_rd_valid;
   logic [14:0] ea_addr;
   logic [11:0] fld_rd_word;
   logic [2:0]  field_df, field_if, field_ib;

   int checks = 0, errors = 0;
   logic [11:0] mem [logic [14:0]];

   always #2 clk = ~clk;

   paged_ea_unit uut (.*);

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (mem_we) mem[mem_addr] = mem_wdata;
         else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 12'd0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0o expected %0o", req, act, exp);
      end
   endtask

   task automatic run_ea(input logic [11:0] ins, input logic [11:0] pc,
                         output logic [14:0] a, output int lat, output logic j);
      @(negedge clk);
      ea_instr = ins; ea_fetch_pc = pc; ea_start = 1'b1;
      @(posedge clk); #1;
      ea_start = 1'b0;
      lat = 1;
      while (!ea_done && lat < 20) begin
         @(posedge clk); #1;
         lat++;
      end
      a = ea_addr; j = ea_jump;
      @(posedge clk); #1;
      chk("R11 done single cycle", int'(ea_done), 0);
   endtask

   task automatic iot(input logic [5:0] dev, input logic [2:0] pl);
      @(negedge clk);
      iot_valid = 1'b1; iot_dev = dev; iot_pulse = pl;
      @(negedge clk);
      iot_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R12 df", int'(field_df), 0);
      chk("R12 if", int'(field_if), 0);
      chk("R12 ib", int'(field_ib), 0);
      chk("R12 done", int'(ea_done), 0);
      chk("R12 req", int'(mem_req), 0);
   endtask

   task automatic t_direct();
      logic [14:0] a; int lat; logic j;
      iot(6'o25, 3'd1);
      chk("R6 cdf", int'(field_df), 5);
      chk("R6 if untouched", int'(field_if), 0);
      run_ea(12'o1023, 12'o4567, a, lat, j);
      chk("R1 page zero", int'(a), 15'o00023);
      chk("R11 direct latency", lat, 1);
      run_ea(12'o1223, 12'o4567, a, lat, j);
      chk("R2 current page", int'(a), 15'o04423);
      chk("R3 direct uses if", int'(a[14:12]), 0);
   endtask

   task automatic t_indirect();
      logic [14:0] a; int lat; logic j;
      mem[15'o00020] = 12'o3456;
      mem[15'o50020] = 12'o7070;
      run_ea(12'o1420, 12'o0100, a, lat, j);
      chk("R4 indirect df", int'(a), 15'o53456);
      chk("R11 indirect latency", lat, 3);
      chk("R5 no writeback", int'(mem[15'o00020]), 12'o3456);
   endtask

   task automatic t_autoinc();
      logic [14:0] a; int lat; logic j;
      mem[15'o00012] = 12'o0777;
      run_ea(12'o1412, 12'o0100, a, lat, j);
      chk("R5 autoinc address", int'(a), 15'o51000);
      chk("R5 autoinc written", int'(mem[15'o00012]), 12'o1000);
      chk("R11 autoinc latency", lat, 4);
      mem[15'o00017] = 12'o7777;
      run_ea(12'o0417, 12'o0100, a, lat, j);
      chk("R5 wrap address", int'(a), 15'o50000);
      chk("R5 wrap written", int'(mem[15'o00017]), 0);
   endtask

   task automatic t_jump();
      logic [14:0] a; int lat; logic j;
      iot(6'o23, 3'd2);
      chk("R7 ib loaded", int'(field_ib), 3);
      chk("R7 if held", int'(field_if), 0);
      chk("R7 df held", int'(field_df), 5);
      run_ea(12'o1023, 12'o0100, a, lat, j);
      chk("R7 non-jump keeps if", int'(field_if), 0);
      chk("R3 still if 0", int'(a[14:12]), 0);
      run_ea(12'o5200, 12'o2345, a, lat, j);
      chk("R9 direct jump", int'(a), 15'o32200);
      chk("R9 jump flag", int'(j), 1);
      chk("R7 if after jump", int'(field_if), 3);
      iot(6'o24, 3'd3);
      chk("R8 df", int'(field_df), 4);
      chk("R8 ib", int'(field_ib), 4);
      chk("R8 if waits", int'(field_if), 3);
      mem[15'o30030] = 12'o1234;
      mem[15'o40030] = 12'o7070;
      run_ea(12'o4430, 12'o0100, a, lat, j);
      chk("R9 indirect jms", int'(a), 15'o41234);
      chk("R7 if after jms", int'(field_if), 4);
   endtask

   task automatic t_readback();
      iot(6'o22, 3'd0);
      chk("R8 pulse 0 no change", int'(field_df), 4);
      iot(6'o21, 3'd1);
      @(negedge clk);
      iot_valid = 1'b1; iot_dev = 6'o21; iot_pulse = 3'd4;
      @(posedge clk); #1;
      iot_valid = 1'b0;
      chk("R10 rdf valid", int'(fld_rd_valid), 1);
      chk("R10 rdf word", int'(fld_rd_word), 12'o0010);
      chk("R10 rdf no change", int'(field_df), 1);
      @(negedge clk);
      iot_valid = 1'b1; iot_dev = 6'o22; iot_pulse = 3'd4;
      @(posedge clk); #1;
      iot_valid = 1'b0;
      chk("R10 rif word", int'(fld_rd_word), 12'o0040);
   endtask

   initial begin
      int wd = 0;
      while (wd < 20000 && checks < 1000) begin
         @(posedge clk);
         wd++;
      end
      if (wd >= 20000) begin
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected below %0d", wd, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_direct();
      t_indirect();
      t_autoinc();
      t_jump();
      t_readback();
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule